// File: doc/BRIEF.md
# Word-Aligned Synchronous-Write Memory

This block is a small storage array of 32-bit words that is reached through a 32-bit byte address. Only addresses that fall on a four-byte boundary name a word. Reads are combinational. When the read enable is high, the addressed word appears on the read-data output within the same cycle, and no clock edge is involved. Writes are synchronous: the input word is captured at the addressed location on the rising clock edge that sees the write enable high.

Accesses that cannot name a real word are refused rather than folded onto some other word. If either of the two lowest address bits is set, the access is misaligned. If the word index lies at or beyond the configured depth, the access is out of range. In either case the array is left untouched, the read data stays at zero, and a combinational fault flag names the reason for as long as the enabled access is held. An active-low reset clears every word, which gives tests a known starting image. The read and write ports carry one word each with no handshake: a read is answered in the same cycle and a write completes at the next edge, so the port never needs to stall.

Top module: `wordmem_sync`

## Requirements
- R1: While `rst_n` is low, every word is cleared to zero on each rising edge. After reset, any aligned in-range read returns 0 until that word is written.
- R2: With `rd_en` high and a valid address, `rd_data` shows the stored word within the same cycle, with no clock edge needed.
- R3: While `rd_en` is low, `rd_data` is zero whatever the address.
- R4: With `wr_en` high and a valid address, `wr_data` is stored at word index `addr[IDX_W+1:2]` on the rising edge. Different indices hold independent words, and the lowest and highest indices (byte addresses 0 and 4*(DEPTH-1)) are usable.
- R5: While `wr_en` is low, no word changes, whatever `wr_data` and `addr` carry.
- R6: An address is misaligned when `addr[1:0]` is not 00. An enabled misaligned access raises `misalign_err` for as long as it is held, reads 0, and does not change the word at `addr & ~3`.
- R7: An aligned address with `addr[31:2] >= DEPTH` is out of range. An enabled out-of-range access raises `range_err`, reads 0, and changes no word: it does not alias onto a low index. `misalign_err` and `range_err` never assert together.
- R8: When neither enable is high, both fault flags are low, even if the address is misaligned or out of range.
- R9: With read and write both enabled on the same valid address, `rd_data` shows the old word until the edge and the new word after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the array |
| addr | input | 32 | Byte address of the access |
| wr_data | input | 32 | Word to be written |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| rd_data | output | 32 | Read word, zero when not a valid enabled read |
| misalign_err | output | 1 | Enabled access has addr[1:0] != 0 |
| range_err | output | 1 | Enabled aligned access beyond the configured depth |

## Verification
The bench writes to address 0x100, which is one word past a 64-word array. A design that truncates the address to a word index would put that data in word 0, and the read of address 0 that follows would show it. Writes to misaligned addresses such as 0x12 are followed by a read of the aligned neighbour, 0x10, which catches a design that drops the low bits and writes anyway. A combined read and write to the same word is checked before and after the edge, which exposes write-through or a registered read. The bench also presents faulty addresses with both enables low to confirm that the flags stay quiet, and it drives a write with the enable low to confirm that no word changes.

// File: rtl/wordmem_pkg.sv
package wordmem_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned OFFS_W     = $clog2(WORD_BYTES);

  typedef struct packed {
    logic misalign;
    logic out_of_range;
    logic usable;
  } addr_class_t;
endpackage

// File: rtl/wordmem_addr_check.sv
module wordmem_addr_check
  import wordmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_class_t       cls,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned WIDX_W = ADDR_W - OFFS_W;
  localparam logic [WIDX_W-1:0] DEPTH_V = WIDX_W'(DEPTH);

  logic [WIDX_W-1:0] word_idx;

  always_comb begin
    word_idx         = addr[ADDR_W-1:OFFS_W];
    cls.misalign     = |addr[OFFS_W-1:0];
    cls.out_of_range = !cls.misalign && (word_idx >= DEPTH_V);
    cls.usable       = !cls.misalign && !cls.out_of_range;
    idx              = word_idx[IDX_W-1:0];
  end
endmodule

// File: rtl/wordmem_array.sv
module wordmem_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = we && (idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n)   words[w] <= '0;
      else if (hit) words[w] <= din;
    end
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < DEPTH; k++)
      if (idx == IDX_W'(k)) dout = words[k];
  end
endmodule

// File: rtl/wordmem_sync.sv
module wordmem_sync
  import wordmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              misalign_err,
  output logic              range_err
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  addr_class_t       cls;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] arr_q;
  logic              access;

  wordmem_addr_check #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .addr (addr),
    .cls  (cls),
    .idx  (idx)
  );

  wordmem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en && cls.usable),
    .idx   (idx),
    .din   (wr_data),
    .dout  (arr_q)
  );

  assign access       = rd_en || wr_en;
  assign misalign_err = access && cls.misalign;
  assign range_err    = access && cls.out_of_range;
  assign rd_data      = (rd_en && cls.usable) ? arr_q : '0;
endmodule

// File: rtl/wordmem_sync_chk.sv
module wordmem_sync_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              misalign_err,
  input logic              range_err
);
  assert_idle_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  assert_misalign_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> rd_data == '0);

  assert_range_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> rd_data == '0);

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(misalign_err && range_err));

  assert_flags_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> !misalign_err && !range_err);

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && !$past(misalign_err) && !$past(range_err)
     && rd_en && addr == $past(addr)) |-> rd_data == $past(wr_data));

  assert_no_write_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $past(rd_en) && rd_en && $stable(addr))
      |-> $stable(rd_data));
endmodule

bind wordmem_sync wordmem_sync_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wordmem_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .wr_data      (wr_data),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .rd_data      (rd_data),
  .misalign_err (misalign_err),
  .range_err    (range_err)
);

// File: tb/tb_wordmem_sync.sv
module tb_wordmem_sync;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr, wr_data, rd_data;
  logic        rd_en, wr_en, misalign_err, range_err;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  wordmem_sync #(.ADDR_W(32), .DATA_W(32), .DEPTH(64)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data),
    .misalign_err(misalign_err), .range_err(range_err)
  );

  typedef struct packed {
    logic [1:0]  op;   // bit1 = write, bit0 = read
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] exp;  // expected rd_data before the edge
    logic        mis;
    logic        rng;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam logic [103:0] VECS [NV] = '{
    {2'b10, 32'h10,  32'h12345678, 32'h0,        1'b0, 1'b0, 4'd4}, // R4 write
    {2'b10, 32'h18,  32'h89abcdef, 32'h0,        1'b0, 1'b0, 4'd4}, // R4 write
    {2'b01, 32'h10,  32'h0,        32'h12345678, 1'b0, 1'b0, 4'd2}, // R2 read
    {2'b01, 32'h18,  32'h0,        32'h89abcdef, 1'b0, 1'b0, 4'd2}, // R2 read
    {2'b01, 32'h14,  32'h0,        32'h0,        1'b0, 1'b0, 4'd1}, // R1 cleared word
    {2'b10, 32'h12,  32'hdeadbeef, 32'h0,        1'b1, 1'b0, 4'd6}, // R6 misaligned write
    {2'b01, 32'h10,  32'h0,        32'h12345678, 1'b0, 1'b0, 4'd6}, // R6 neighbour intact
    {2'b01, 32'h11,  32'h0,        32'h0,        1'b1, 1'b0, 4'd6}, // R6 misaligned read
    {2'b10, 32'h100, 32'hcafef00d, 32'h0,        1'b0, 1'b1, 4'd7}, // R7 write past end
    {2'b01, 32'h0,   32'h0,        32'h0,        1'b0, 1'b0, 4'd7}, // R7 no alias
    {2'b01, 32'h100, 32'h0,        32'h0,        1'b0, 1'b1, 4'd7}, // R7 read past end
    {2'b00, 32'h13,  32'h0,        32'h0,        1'b0, 1'b0, 4'd8}, // R8 idle, misaligned
    {2'b00, 32'h200, 32'h0,        32'h0,        1'b0, 1'b0, 4'd8}, // R8 idle, past end
    {2'b11, 32'h10,  32'h0badc0de, 32'h12345678, 1'b0, 1'b0, 4'd9}, // R9 old before edge
    {2'b01, 32'h10,  32'h0,        32'h0badc0de, 1'b0, 1'b0, 4'd9}, // R9 new after edge
    {2'b00, 32'h10,  32'hffffffff, 32'h0,        1'b0, 1'b0, 4'd3}, // R3 no read enable
    {2'b00, 32'h18,  32'hffffffff, 32'h0,        1'b0, 1'b0, 4'd5}, // R5 write disabled
    {2'b01, 32'h18,  32'h0,        32'h89abcdef, 1'b0, 1'b0, 4'd5}, // R5 word kept
    {2'b10, 32'hfc,  32'h55aa55aa, 32'h0,        1'b0, 1'b0, 4'd4}, // R4 top word
    {2'b01, 32'hfc,  32'h0,        32'h55aa55aa, 1'b0, 1'b0, 4'd4}, // R4 top word read
    {2'b01, 32'hfe,  32'h0,        32'h0,        1'b1, 1'b0, 4'd6}  // R6 misaligned top
  };

  task automatic check(input int tag, input logic [31:0] e, input logic em, input logic er);
    checks++;
    if (rd_data !== e || misalign_err !== em || range_err !== er) begin
      fails++;
      $display("FAIL R%0d: rd_data=%h mis=%b rng=%b, expected rd_data=%h mis=%b rng=%b",
               tag, rd_data, misalign_err, range_err, e, em, er);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = op[1]; rd_en = op[0]; addr = a; wr_data = d;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    drive(2'b01, 32'h10, 32'h0);
    check(1, 32'h0, 1'b0, 1'b0); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.op, v.a, v.d);
      check(int'(v.req), v.exp, v.mis, v.rng);
    end
    // R2: output follows the address with no clock edge in between
    drive(2'b01, 32'h10, 32'h0);
    addr = 32'h18; #0.5;
    check(2, 32'h89abcdef, 1'b0, 1'b0);
    // R1: reset reapplied clears written words
    @(negedge clk) rst_n = 1'b0; rd_en = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(2'b01, 32'h18, 32'h0);
    check(1, 32'h0, 1'b0, 1'b0);
    drive(2'b01, 32'hfc, 32'h0);
    check(1, 32'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule